// File: doc/BRIEF.md
# Read-Only Diagnostic SPI Slave

This block is a serial slave that a host controller polls for identification and fault status. The host lowers select and clocks exactly sixteen bits. It shifts in an instruction byte, MSB first. At the same time the slave returns a verification byte, then a data byte. The data byte holds a fixed identifier, a fixed revision value, or the live value of an 8-bit diagnostic word that surrounding logic presents on a parallel input. The slave never accepts writes.

The serial pins are oversampled in the system clock domain. Incoming data is taken on each falling SCK edge. Outgoing data changes after each rising edge. The output enable stays low whenever the slave must leave the shared line undriven. Two bits of the instruction form a chip address, so that several slaves can share one select line. A frame that breaks the protocol is flagged in the verification byte of the next frame. A completed read of the diagnostic word produces a one-cycle strobe, so that the owner of that word can clear or refresh it.

Top module: `spi_diag_slave`

## Requirements
- R1: Frame position p (0 to 15) is the bit the slave samples at the p-th falling SCK edge of a frame. The instruction is received MSB first at positions 0 to 7. The slave also drives its bit for position p after the rising edge that precedes that falling edge.
- R2: While select (active low) is high, the output enable is 0.
- R3: At positions 0 and 1, which carry the chip address, the output enable is 0.
- R4: If the two address bits differ from the CHIP_ADDR parameter (default 00), the output enable stays 0 for the rest of the frame. The frame is then ignored: it changes no error flag and produces no read strobe.
- R5: Positions 2 to 6 carry the fixed pattern 1,0,1,0,1, in that order.
- R6: Position 7 carries the error flag, which is 1 when the last non-ignored frame was invalid. A valid frame clears the flag after reporting it.
- R7: The instruction code is bits 5:1 of the instruction byte, and bit 0 is ignored. Code 00000 returns 0xA1, code 00001 returns 0x00, and code 00100 returns the diagnostic input. The data byte goes out MSB first at positions 8 to 15.
- R8: Any other code returns 0xFF and makes the frame invalid.
- R9: A frame with a number of falling SCK edges other than 16 is invalid.
- R10: A frame that starts within BUSY_CYC clock cycles of the previous rise of select is invalid, and it produces no read strobe.
- R11: A valid diagnostic read produces a single-cycle rd_done pulse, following the rise of select.
- R12: A synchronous reset forces the output enable to 0 and rd_done to 0, and clears the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset; also held while the interface supply is too low |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| diag_i | input | 8 | Diagnostic word returned by code 00100 |
| spi_miso | output | 1 | Serial data to the host, valid while spi_miso_oe is 1 |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| rd_done | output | 1 | One-cycle strobe after a valid diagnostic read |

## Verification
The assertions assume that every level on spi_sck, spi_ss_n and spi_mosi lasts at least a few system clocks. They also assume that select never changes within a few cycles of a clock edge. Without this, a rising SCK edge and a select edge could land in the same oversampled cycle, and the address-phase and select-high properties would no longer have a defined order. The stimulus holds each SCK half period for eight system clocks. It changes spi_mosi only together with the rising SCK edge, and it keeps at least eight cycles between select edges and clock edges. The one exception is the back-to-back test, which reopens select six cycles after closing it.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int OP_W      = 5;
  localparam int FRAME_LEN = 2 * BYTE_W;
  localparam int CNT_W     = $clog2(FRAME_LEN) + 1;
  localparam int VPAT_W    = BYTE_W - ADDR_W - 1;

  localparam logic [OP_W-1:0]   OP_IDENT = 5'b00000;
  localparam logic [OP_W-1:0]   OP_REV   = 5'b00001;
  localparam logic [OP_W-1:0]   OP_DIAG  = 5'b00100;
  localparam logic [VPAT_W-1:0] VPAT     = 5'b10101;

  typedef logic [CNT_W-1:0] pos_t;

  function automatic logic op_known(input logic [OP_W-1:0] code);
    return (code == OP_IDENT) || (code == OP_REV) || (code == OP_DIAG);
  endfunction
endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_prev <= RST_VAL;
    else     q_prev <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_diag_frame.sv
module spi_diag_frame
  import spi_diag_pkg::*;
#(
  parameter int BUSY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  output logic              in_frame,
  output pos_t              cnt,
  output logic [OP_W-1:0]   op_code,
  output logic [ADDR_W-1:0] addr_q,
  output logic              overlap
);
  localparam int   SH_W      = BYTE_W - ADDR_W;
  localparam int   BUSY_W    = $clog2(BUSY_CYC + 1);
  localparam pos_t CNT_MAX   = '1;
  localparam pos_t SH_END    = pos_t'(BYTE_W);
  localparam pos_t ADDR_LAST = pos_t'(ADDR_W - 1);

  logic [SH_W-1:0]   sh;
  logic [BUSY_W-1:0] busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      addr_q   <= '0;
      overlap  <= 1'b0;
      busy     <= '0;
    end else begin
      if (busy != '0) busy <= busy - 1'b1;
      if (ss_fall) begin
        in_frame <= 1'b1;
        cnt      <= '0;
        sh       <= '0;
        addr_q   <= '0;
        overlap  <= (busy != '0);
      end else if (ss_rise) begin
        in_frame <= 1'b0;
        busy     <= BUSY_W'(BUSY_CYC);
      end else if (in_frame && sck_fall) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt < SH_END)   sh  <= {sh[SH_W-2:0], mosi_s};
        if (cnt == ADDR_LAST) addr_q <= {sh[ADDR_W-2:0], mosi_s};
      end
    end
  end

  assign op_code = sh[OP_W:1];
endmodule

// File: rtl/spi_diag_status.sv
module spi_diag_status
  import spi_diag_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_rise,
  input  logic              in_frame,
  input  pos_t              cnt,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              overlap,
  output logic              err_flag,
  output logic              rd_done
);
  localparam pos_t FULL      = pos_t'(FRAME_LEN);
  localparam pos_t ADDR_SEEN = pos_t'(ADDR_W);

  logic ignore, valid;

  always_comb begin
    ignore = (cnt >= ADDR_SEEN) && (addr_q != CHIP_ADDR);
    valid  = (cnt == FULL) && !overlap && op_known(op_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      rd_done  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (ss_rise && in_frame && !ignore) begin
        err_flag <= !valid;
        rd_done  <= valid && (op_code == OP_DIAG);
      end
    end
  end
endmodule

// File: rtl/spi_diag_tx.sv
module spi_diag_tx
  import spi_diag_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ADDR = '0,
  parameter logic [BYTE_W-1:0] IDENT     = 8'hA1,
  parameter logic [BYTE_W-1:0] REVISION  = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_fall,
  input  logic              ss_rise,
  input  logic              sck_rise,
  input  logic              in_frame,
  input  pos_t              cnt,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              err_flag,
  input  logic [BYTE_W-1:0] diag_i,
  output logic              miso,
  output logic              miso_oe,
  output logic              mute
);
  localparam pos_t ADDR_END   = pos_t'(ADDR_W);
  localparam pos_t DATA_START = pos_t'(BYTE_W);
  localparam pos_t FULL       = pos_t'(FRAME_LEN);
  localparam int   PAD        = BYTE_W - VPAT_W;

  logic [BYTE_W-1:0] sh, data_byte;
  logic [VPAT_W:0]   verif;
  logic              addr_hit;

  always_comb begin
    verif    = {VPAT, err_flag};
    addr_hit = (addr_q == CHIP_ADDR);
    case (op_code)
      OP_IDENT: data_byte = IDENT;
      OP_REV:   data_byte = REVISION;
      OP_DIAG:  data_byte = diag_i;
      default:  data_byte = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      mute    <= 1'b0;
      sh      <= '0;
    end else if (ss_fall) begin
      miso_oe <= 1'b0;
      mute    <= 1'b0;
    end else if (ss_rise || !in_frame) begin
      miso_oe <= 1'b0;
    end else if (sck_rise) begin
      if (cnt < ADDR_END || cnt >= FULL) begin
        miso_oe <= 1'b0;
      end else begin
        if (cnt == ADDR_END) begin
          mute    <= !addr_hit;
          miso_oe <= addr_hit;
        end else begin
          miso_oe <= !mute;
        end
        if (cnt == ADDR_END) begin
          miso <= verif[VPAT_W];
          sh   <= {verif[VPAT_W-1:0], {PAD{1'b0}}};
        end else if (cnt == DATA_START) begin
          miso <= data_byte[BYTE_W-1];
          sh   <= {data_byte[BYTE_W-2:0], 1'b0};
        end else begin
          miso <= sh[BYTE_W-1];
          sh   <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_diag_slave.sv
module spi_diag_slave
  import spi_diag_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CHIP_ADDR   = '0,
  parameter logic [BYTE_W-1:0] IDENT       = 8'hA1,
  parameter logic [BYTE_W-1:0] REVISION    = 8'h00,
  parameter int                SYNC_STAGES = 2,
  parameter int                BUSY_CYC    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  input  logic [BYTE_W-1:0] diag_i,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              rd_done
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0] pin_s, pin_p;
  logic ss_s, sck_s, mosi_s;
  logic ss_fall, ss_rise, sck_rise, sck_fall;
  logic in_frame, overlap, err_flag, mute;
  pos_t cnt;
  logic [OP_W-1:0]   op_code;
  logic [ADDR_W-1:0] addr_q;

  spi_diag_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) i_sync (
    .clk(clk), .rst(rst), .d({spi_ss_n, spi_sck, spi_mosi}),
    .q(pin_s), .q_prev(pin_p)
  );

  assign ss_s     = pin_s[2];
  assign sck_s    = pin_s[1];
  assign mosi_s   = pin_s[0];
  assign ss_fall  =  pin_p[2] & ~ss_s;
  assign ss_rise  = ~pin_p[2] &  ss_s;
  assign sck_rise = ~pin_p[1] &  sck_s;
  assign sck_fall =  pin_p[1] & ~sck_s;

  spi_diag_frame #(.BUSY_CYC(BUSY_CYC)) i_frame (
    .clk(clk), .rst(rst), .ss_fall(ss_fall), .ss_rise(ss_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .in_frame(in_frame), .cnt(cnt),
    .op_code(op_code), .addr_q(addr_q), .overlap(overlap)
  );

  spi_diag_status #(.CHIP_ADDR(CHIP_ADDR)) i_status (
    .clk(clk), .rst(rst), .ss_rise(ss_rise), .in_frame(in_frame),
    .cnt(cnt), .op_code(op_code), .addr_q(addr_q), .overlap(overlap),
    .err_flag(err_flag), .rd_done(rd_done)
  );

  spi_diag_tx #(
    .CHIP_ADDR(CHIP_ADDR), .IDENT(IDENT), .REVISION(REVISION)
  ) i_tx (
    .clk(clk), .rst(rst), .ss_fall(ss_fall), .ss_rise(ss_rise),
    .sck_rise(sck_rise), .in_frame(in_frame), .cnt(cnt), .op_code(op_code),
    .addr_q(addr_q), .err_flag(err_flag), .diag_i(diag_i),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .mute(mute)
  );
endmodule

// File: rtl/spi_diag_chk.sv
module spi_diag_chk
  import spi_diag_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic ss_hi,
  input logic ss_rise,
  input logic sck_rise,
  input pos_t cnt,
  input logic mute,
  input logic oe,
  input logic rd_done
);
  localparam pos_t ADDR_END = pos_t'(ADDR_W);

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (rst)
    (ss_hi && $past(ss_hi)) |-> !oe);                         // R2
  AST_ADDR_HIZ: assert property (@(posedge clk) disable iff (rst)
    (sck_rise && cnt < ADDR_END) |=> !oe);                    // R3
  AST_MUTE_HIZ: assert property (@(posedge clk) disable iff (rst)
    mute |-> !oe);                                            // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);                                    // R11
  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(ss_rise));                              // R11
endmodule

bind spi_diag_slave spi_diag_chk i_chk (
  .clk(clk), .rst(rst), .ss_hi(ss_s), .ss_rise(ss_rise),
  .sck_rise(sck_rise), .cnt(cnt), .mute(mute), .oe(spi_miso_oe),
  .rd_done(rd_done)
);

// File: tb/test_spi_diag_slave.sv
module test_spi_diag_slave;
  localparam int H = 8;
  localparam int NVEC = 13;
  // {instr[31:24], nclk[23:19], diag[18:11], data[10:3], flag[2], drive[1], done[0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 5'd16, 8'h00, 8'hA1, 3'b010},  // R7 identifier
    {8'h03, 5'd16, 8'h00, 8'h00, 3'b010},  // R7 revision, bit 0 ignored
    {8'h08, 5'd16, 8'h5C, 8'h5C, 3'b011},  // R7 R11 diagnostic
    {8'h0A, 5'd16, 8'h00, 8'hFF, 3'b010},  // R8 unused code
    {8'h00, 5'd16, 8'h00, 8'hA1, 3'b110},  // R6 flag reported
    {8'h00, 5'd16, 8'h00, 8'hA1, 3'b010},  // R6 flag cleared
    {8'h48, 5'd16, 8'h00, 8'h00, 3'b000},  // R4 address 01
    {8'h00, 5'd15, 8'h00, 8'hA1, 3'b010},  // R9 short frame
    {8'h08, 5'd16, 8'h3E, 8'h3E, 3'b111},  // R9 flag seen
    {8'h00, 5'd17, 8'h00, 8'hA1, 3'b010},  // R9 long frame
    {8'hC8, 5'd16, 8'h00, 8'h00, 3'b000},  // R4 ignored, flag kept
    {8'h09, 5'd16, 8'hA7, 8'hA7, 3'b111},  // R4 R6 flag survived
    {8'h08, 5'd16, 8'hA7, 8'hA7, 3'b011}   // R11
  };

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [7:0] diag = 8'h00;
  logic miso, miso_oe, rd_done;
  int checks = 0, errs = 0, done_cnt = 0, done0 = 0;
  logic rb_v [32];
  logic rb_oe [32];

  always #2.5 clk = ~clk;

  spi_diag_slave i_spi_diag_slave (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_ss_n(ss_n), .spi_mosi(mosi),
    .diag_i(diag), .spi_miso(miso), .spi_miso_oe(miso_oe), .rd_done(rd_done)
  );

  always @(posedge clk) if (rd_done === 1'b1) done_cnt++;

  task automatic chk(input bit ok, input string req, input logic [15:0] got,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] instr, input int nclk, input int gap);
    done0 = done_cnt;
    ss_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sck  = 1'b1;
      mosi = (i < 8) ? instr[7-i] : 1'b1;
      repeat (H) @(negedge clk);
      rb_v[i]  = miso;
      rb_oe[i] = miso_oe;
      sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    ss_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_frame(input int nclk, input logic flag, input logic [7:0] data,
                             input logic drive, input int done);
    int lim;
    logic [15:0] oe_got, oe_exp, gd, ed;
    lim = (nclk < 16) ? nclk : 16;
    oe_got = '0; oe_exp = '0; gd = '0;
    for (int p = 0; p < lim; p++) begin
      oe_got[p] = rb_oe[p];
      oe_exp[p] = (p >= 2) && drive;
    end
    chk(oe_got === oe_exp, "R3 R4 enable", oe_got, oe_exp);
    if (drive && lim >= 8) begin
      for (int p = 2; p < 8; p++) gd = {gd[14:0], rb_v[p]};
      chk(gd[5:0] === {5'b10101, flag}, "R5 R6 verification", gd, {10'd0, 5'b10101, flag});
    end
    if (drive && lim > 8) begin
      gd = '0;
      for (int p = 8; p < lim; p++) gd = {gd[14:0], rb_v[p]};
      ed = 16'(data >> (16 - lim));
      chk(gd === ed, "R1 R7 R8 R9 data", gd, ed);
    end
    chk((done_cnt - done0) == done, "R11 strobe", 16'(done_cnt - done0), 16'(done));
    chk(miso_oe === 1'b0, "R2 deselected", {15'd0, miso_oe}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(miso_oe === 1'b0 && rd_done === 1'b0, "R12 reset", {miso_oe, rd_done}, 16'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      diag = VEC[v][18:11];
      run_frame(VEC[v][31:24], int'(VEC[v][23:19]), 40);
      check_frame(int'(VEC[v][23:19]), VEC[v][2], VEC[v][10:3], VEC[v][1], int'(VEC[v][0]));
    end

    // R10: second frame opens six cycles after the first closes
    diag = 8'h11;
    run_frame(8'h08, 16, 6);
    check_frame(16, 1'b0, 8'h11, 1'b1, 1);
    run_frame(8'h08, 16, 40);
    check_frame(16, 1'b0, 8'h11, 1'b1, 0);
    run_frame(8'h00, 16, 40);
    check_frame(16, 1'b1, 8'hA1, 1'b1, 0);  // R10 error reported
    run_frame(8'h00, 16, 40);
    check_frame(16, 1'b0, 8'hA1, 1'b1, 0);

    // R12: reset clears a pending error flag
    run_frame(8'h3E, 16, 40);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(miso_oe === 1'b0 && rd_done === 1'b0, "R12 in reset", {miso_oe, rd_done}, 16'd0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    run_frame(8'h00, 16, 40);
    check_frame(16, 1'b0, 8'hA1, 1'b1, 0);  // R12 flag cleared

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule